// File: doc/BRIEF.md
# Flash command front-end controller

This block sits between a host register bus and an embedded flash array. Software loads an address register and a 32-bit data register, then writes a command code into a control register. The block captures the command into a single pending slot and offers it to the flash array over a valid/ready request port. The array later reports each completion with a one-cycle done pulse. The host learns the outcome through a status register and five interrupt sources. Each interrupt source has set, clear and enable registers, and all of them are merged onto one interrupt line.

Read commands fetch a 128-bit word from a 16-byte aligned address into four data registers. Word writes and row writes program the 32-bit data register. Page erase and mass erase pass the address through unchanged; for mass erase, address bit 21 selects whether the extended area is included. Row writes overlap: a second row write may be issued while the first is still being programmed. A completion that arrives while an earlier success or fail is still uncleared is held back and marked as finished. The block posts it once software has cleared those bits.

Request port rules: the request fields are stable while `fl_req_valid` is high. A transfer happens on a cycle where both `fl_req_valid` and `fl_req_ready` are high. `fl_req_ready` may be held low for any number of cycles, and the request then waits. The only way a request is withdrawn before acceptance is an abort write. The completion side has no back-pressure: every `fl_done` pulse is taken in the cycle it arrives.

Top module: `flash_cmd_frontend`

## Requirements
- R1: After reset the status register (0x18), raw interrupt status (0x08), interrupt enable (0x00) and `irq` are all zero, and `fl_req_valid` is low.
- R2: A control write (0x14) with code 1 (read), 2 (word write), 3 (row write), 4 (page erase) or 7 (mass erase) in bits [2:0] and bit 4 clear is a command write. If the arbitration lock is low and no command is pending, it sets status bit 0 (pending). From the next cycle `fl_req_valid` goes high with that code on `fl_req_cmd`. Every such command reaches the request port exactly once.
- R3: While `fl_req_valid` is high and `fl_req_ready` is low, the request and its fields hold. At the handshake, pending clears and interrupt bit 0 (accepted) sets, which is shown as status bit 1.
- R4: A read request carries the address register with its low four bits forced to zero. Its completion loads the 128-bit word into the data registers 0x20, 0x24, 0x28 and 0x2C, which hold bits [31:0], [63:32], [95:64] and [127:96].
- R5: Write and row-write requests carry the data register 0x20 value from the time of the control write. Erase requests carry the full address, including bit 21 for mass erase.
- R6: When interrupt bits 1 and 2 are both clear, a completion with `fl_done_fail` low sets interrupt bit 1 (success, status bit 2). With `fl_done_fail` high it sets interrupt bit 2 (fail, status bit 3).
- R7: A completion that arrives while success or fail is set leaves both unchanged and sets status bit 4 (finished). The cycle after both have been cleared, the held result is posted and bit 4 clears.
- R8: A row write may be issued while exactly one row write is outstanding, so an accepted flag and a success flag can both be set at once. Any other command waits until nothing is outstanding.
- R9: A command write while a command is pending sets interrupt bit 4 (overflow) and is dropped.
- R10: A command write with code 5 or 6, or one made while `arb_locked` is high, sets interrupt bit 3 (rejected) and issues no request. Status bit 5 follows `arb_locked`. A control write of code 0 with bit 4 clear has no effect.
- R11: A control write with bit 4 set is an abort. It clears a pending command that is not being handed over in that cycle, and `fl_req_valid` is low from the next cycle. Its code field is ignored.
- R12: Writing ones to 0x00 sets enable bits and to 0x04 clears them; both addresses read back the enable. Writing ones to 0x08 sets raw status bits and to 0x0C clears them; both addresses read back the raw status. A hardware set in the same cycle wins over a software clear. Only bits [4:0] exist. The masked status at 0x10 is raw AND enable, and `irq` is the OR of the masked bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe (single cycle) |
| bus_write | input | 1 | Access is a write |
| bus_addr | input | BUS_AW | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| arb_locked | input | 1 | Flash currently owned by another master |
| fl_req_valid | output | 1 | Command request offered to the array |
| fl_req_ready | input | 1 | Array takes the request |
| fl_req_cmd | output | 3 | Command code of the request |
| fl_req_addr | output | FL_AW | Request address |
| fl_req_wdata | output | 32 | Word to program |
| fl_done | input | 1 | One-cycle completion of the oldest outstanding command |
| fl_done_fail | input | 1 | Completion outcome is a failure |
| fl_rdata | input | WORD_W | Read word, valid with `fl_done` |
| irq | output | 1 | OR of the masked interrupt status |

## Verification
The assertions take for granted that the array pulses `fl_done` only while at least one command is outstanding, at most once per accepted command, and in acceptance order. They also take for granted that register writes are single-cycle strobes. The stimulus keeps within these limits by pulsing the done input only after the scoreboard has seen the matching handshake. It toggles `fl_req_ready` freely, including holding it low across overflow and abort cases. It never reports more completions than commands it has accepted.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  localparam int NIRQ = 5;

  localparam logic [2:0] CMD_READ  = 3'd1;
  localparam logic [2:0] CMD_WORD  = 3'd2;
  localparam logic [2:0] CMD_ROW   = 3'd3;
  localparam logic [2:0] CMD_PAGE  = 3'd4;
  localparam logic [2:0] CMD_MASS  = 3'd7;

  localparam int IRQ_ACC = 0;
  localparam int IRQ_OK  = 1;
  localparam int IRQ_ERR = 2;
  localparam int IRQ_REJ = 3;
  localparam int IRQ_OVF = 4;

  localparam int OFS_IEN_SET = 'h00;
  localparam int OFS_IEN_CLR = 'h04;
  localparam int OFS_IST_SET = 'h08;
  localparam int OFS_IST_CLR = 'h0C;
  localparam int OFS_IMASK   = 'h10;
  localparam int OFS_CTRL    = 'h14;
  localparam int OFS_STAT    = 'h18;
  localparam int OFS_ADDR    = 'h1C;
  localparam int OFS_DATA0   = 'h20;

  localparam int CTRL_ABORT_BIT = 4;

  function automatic logic cmd_is_known(input logic [2:0] c);
    case (c)
      CMD_READ, CMD_WORD, CMD_ROW, CMD_PAGE, CMD_MASS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fe_cmd_slot.sv
module fe_cmd_slot
  import flash_fe_pkg::*;
#(
  parameter int FL_AW = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [2:0]       load_cmd,
  input  logic [FL_AW-1:0] load_addr,
  input  logic [31:0]      load_wdata,
  input  logic             abort,
  input  logic             req_ready,
  input  logic             done,
  output logic             pend,
  output logic             req_valid,
  output logic [2:0]       req_cmd,
  output logic [FL_AW-1:0] req_addr,
  output logic [31:0]      req_wdata,
  output logic             hs,
  output logic             head_read
);
  logic [1:0] cnt_q;
  logic       infl_row_q, infl_read_q;
  logic       can_issue;

  assign can_issue = (cnt_q == 2'd0) ||
                     (cnt_q == 2'd1 && infl_row_q && req_cmd == CMD_ROW);
  assign req_valid = pend && can_issue;
  assign hs        = req_valid && req_ready;
  assign head_read = infl_read_q && (cnt_q != 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      req_cmd   <= '0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else if (hs) begin
      pend <= 1'b0;
    end else if (abort) begin
      pend <= 1'b0;
    end else if (load) begin
      pend      <= 1'b1;
      req_cmd   <= load_cmd;
      req_addr  <= load_addr;
      req_wdata <= load_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      infl_row_q  <= 1'b0;
      infl_read_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 2'(hs) - 2'(done);
      if (hs) begin
        infl_row_q  <= (req_cmd == CMD_ROW);
        infl_read_q <= (req_cmd == CMD_READ);
      end
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !abort |=> req_valid && $stable(req_cmd) && $stable(req_addr)); // R3
  AST_DONE_NEEDS_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cnt_q != 2'd0); // R6
  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != 2'd3); // R8
endmodule

// File: rtl/fe_result_track.sv
module fe_result_track (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic done_fail,
  input  logic raw_ok,
  input  logic raw_err,
  output logic post_ok,
  output logic post_err,
  output logic fin
);
  logic fin_err_q;
  logic busy, direct, release_held;

  assign busy         = raw_ok || raw_err || fin;
  assign direct       = done && !busy;
  assign release_held = fin && !raw_ok && !raw_err && !done;
  assign post_ok      = (direct && !done_fail) || (release_held && !fin_err_q);
  assign post_err     = (direct && done_fail)  || (release_held && fin_err_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin       <= 1'b0;
      fin_err_q <= 1'b0;
    end else if (done && busy) begin
      fin       <= 1'b1;
      fin_err_q <= done_fail;
    end else if (release_held) begin
      fin <= 1'b0;
    end
  end

  AST_FIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    fin && (raw_ok || raw_err) |=> fin); // R7
endmodule

// File: rtl/fe_irq_bank.sv
module fe_irq_bank
  import flash_fe_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_set_we,
  input  logic            en_clr_we,
  input  logic            st_set_we,
  input  logic            st_clr_we,
  input  logic [NIRQ-1:0] wd,
  input  logic [NIRQ-1:0] hw_set,
  output logic [NIRQ-1:0] raw,
  output logic [NIRQ-1:0] en,
  output logic [NIRQ-1:0] masked,
  output logic            irq
);
  logic [NIRQ-1:0] sw_set, sw_clr, en_s, en_c;

  assign sw_set = st_set_we ? wd : '0;
  assign sw_clr = st_clr_we ? wd : '0;
  assign en_s   = en_set_we ? wd : '0;
  assign en_c   = en_clr_we ? wd : '0;
  assign masked = raw & en;
  assign irq    = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw <= '0;
      en  <= '0;
    end else begin
      raw <= (raw & ~sw_clr) | sw_set | hw_set;
      en  <= (en & ~en_c) | en_s;
    end
  end

  AST_HW_SET_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> (raw & $past(hw_set)) == $past(hw_set)); // R12
endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
  import flash_fe_pkg::*;
#(
  parameter int BUS_AW = 6,
  parameter int FL_AW  = 22,
  parameter int WORD_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              arb_locked,
  output logic              fl_req_valid,
  input  logic              fl_req_ready,
  output logic [2:0]        fl_req_cmd,
  output logic [FL_AW-1:0]  fl_req_addr,
  output logic [31:0]       fl_req_wdata,
  input  logic              fl_done,
  input  logic              fl_done_fail,
  input  logic [WORD_W-1:0] fl_rdata,
  output logic              irq
);
  localparam int LANES = WORD_W / 32;

  logic wr_en;
  assign wr_en = bus_valid && bus_write;

  function automatic logic at(input logic [BUS_AW-1:0] a, input int ofs);
    return a == BUS_AW'(ofs);
  endfunction

  logic we_ctrl, we_addr, we_data0;
  assign we_ctrl  = wr_en && at(bus_addr, OFS_CTRL);
  assign we_addr  = wr_en && at(bus_addr, OFS_ADDR);
  assign we_data0 = wr_en && at(bus_addr, OFS_DATA0);

  logic [2:0] code;
  logic abort, try_cmd, bad_cmd, rej, ovf, load, pend;
  assign code    = bus_wdata[2:0];
  assign abort   = we_ctrl && bus_wdata[CTRL_ABORT_BIT];
  assign try_cmd = we_ctrl && !bus_wdata[CTRL_ABORT_BIT] && (code != 3'd0);
  assign bad_cmd = !cmd_is_known(code) || arb_locked;
  assign rej     = try_cmd && bad_cmd;
  assign ovf     = try_cmd && !bad_cmd && pend;
  assign load    = try_cmd && !bad_cmd && !pend;

  logic [FL_AW-1:0] addr_q, load_addr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (we_addr) addr_q <= bus_wdata[FL_AW-1:0];
  end
  assign load_addr = (code == CMD_READ) ? {addr_q[FL_AW-1:4], 4'h0} : addr_q;

  logic hs, head_read, capture;
  logic [31:0] data_q [LANES];
  assign capture = fl_done && head_read;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                data_q[i] <= '0;
      else if (capture)          data_q[i] <= fl_rdata[32*i +: 32];
      else if (i == 0 && we_data0) data_q[i] <= bus_wdata;
    end
  end

  fe_cmd_slot #(.FL_AW(FL_AW)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(load), .load_cmd(code),
    .load_addr(load_addr), .load_wdata(data_q[0]), .abort(abort),
    .req_ready(fl_req_ready), .done(fl_done), .pend(pend),
    .req_valid(fl_req_valid), .req_cmd(fl_req_cmd), .req_addr(fl_req_addr),
    .req_wdata(fl_req_wdata), .hs(hs), .head_read(head_read)
  );

  logic [NIRQ-1:0] raw, en, masked, hw_set;
  logic post_ok, post_err, fin;

  fe_result_track u_result (
    .clk(clk), .rst_n(rst_n), .done(fl_done), .done_fail(fl_done_fail),
    .raw_ok(raw[IRQ_OK]), .raw_err(raw[IRQ_ERR]),
    .post_ok(post_ok), .post_err(post_err), .fin(fin)
  );

  always_comb begin
    hw_set          = '0;
    hw_set[IRQ_ACC] = hs;
    hw_set[IRQ_OK]  = post_ok;
    hw_set[IRQ_ERR] = post_err;
    hw_set[IRQ_REJ] = rej;
    hw_set[IRQ_OVF] = ovf;
  end

  fe_irq_bank u_irq (
    .clk(clk), .rst_n(rst_n),
    .en_set_we(wr_en && at(bus_addr, OFS_IEN_SET)),
    .en_clr_we(wr_en && at(bus_addr, OFS_IEN_CLR)),
    .st_set_we(wr_en && at(bus_addr, OFS_IST_SET)),
    .st_clr_we(wr_en && at(bus_addr, OFS_IST_CLR)),
    .wd(bus_wdata[NIRQ-1:0]), .hw_set(hw_set),
    .raw(raw), .en(en), .masked(masked), .irq(irq)
  );

  logic [31:0] status;
  assign status = {26'd0, arb_locked, fin, raw[IRQ_ERR], raw[IRQ_OK], raw[IRQ_ACC], pend};

  always_comb begin
    bus_rdata = '0;
    if (at(bus_addr, OFS_IEN_SET) || at(bus_addr, OFS_IEN_CLR)) bus_rdata = 32'(en);
    if (at(bus_addr, OFS_IST_SET) || at(bus_addr, OFS_IST_CLR)) bus_rdata = 32'(raw);
    if (at(bus_addr, OFS_IMASK)) bus_rdata = 32'(masked);
    if (at(bus_addr, OFS_STAT))  bus_rdata = status;
    if (at(bus_addr, OFS_ADDR))  bus_rdata = 32'(addr_q);
    for (int i = 0; i < LANES; i++)
      if (at(bus_addr, OFS_DATA0 + 4 * i)) bus_rdata = data_q[i];
  end

  AST_READ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req_valid && fl_req_cmd == CMD_READ |-> fl_req_addr[3:0] == 4'h0); // R4
  AST_REJECT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    we_ctrl && !bus_wdata[CTRL_ABORT_BIT] && (code != 3'd0) && bad_cmd && !pend |=> !fl_req_valid); // R10
  AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort && !(fl_req_valid && fl_req_ready) |=> !fl_req_valid); // R11
endmodule

// File: tb/flash_cmd_frontend_bench.sv
module flash_cmd_frontend_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic arb_locked = 1'b0;
  logic fl_req_valid, fl_req_ready = 1'b0;
  logic [2:0] fl_req_cmd;
  logic [21:0] fl_req_addr;
  logic [31:0] fl_req_wdata;
  logic fl_done = 1'b0, fl_done_fail = 1'b0;
  logic [127:0] fl_rdata = '0;
  logic irq;

  always #5 clk = ~clk;

  flash_cmd_frontend u_flash_cmd_frontend (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .arb_locked(arb_locked), .fl_req_valid(fl_req_valid), .fl_req_ready(fl_req_ready),
    .fl_req_cmd(fl_req_cmd), .fl_req_addr(fl_req_addr), .fl_req_wdata(fl_req_wdata),
    .fl_done(fl_done), .fl_done_fail(fl_done_fail), .fl_rdata(fl_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [2:0]  cmd;
    logic [21:0] addr;
    logic [31:0] wd;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    bus_addr = 6'(a);
    #1 v = bus_rdata;
  endtask

  task automatic rd_check(input int a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    check(v == exp, tag, 64'(v), 64'(exp));
  endtask

  task automatic fdone(input logic fail, input logic [127:0] d);
    fl_done = 1'b1; fl_done_fail = fail; fl_rdata = d;
    @(negedge clk);
    fl_done = 1'b0; fl_done_fail = 1'b0;
  endtask

  task automatic push(input logic [2:0] c, input logic [21:0] a, input logic [31:0] d);
    exp_q.push_back('{cmd: c, addr: a, wd: d});
  endtask

  // Scoreboard monitor: every handshake must match the oldest expected request
  initial forever begin
    @(negedge clk);
    #2;
    if (rst_n && fl_req_valid && fl_req_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected request", 64'(fl_req_cmd), 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(fl_req_cmd == e.cmd, "R2 request code", 64'(fl_req_cmd), 64'(e.cmd));
        if (e.cmd == 3'd1)
          check(fl_req_addr == e.addr, "R4 read address aligned", 64'(fl_req_addr), 64'(e.addr));
        else
          check(fl_req_addr == e.addr, "R5 request address", 64'(fl_req_addr), 64'(e.addr));
        if (e.cmd == 3'd2 || e.cmd == 3'd3)
          check(fl_req_wdata == e.wd, "R5 request write data", 64'(fl_req_wdata), 64'(e.wd));
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_check('h18, 32'h0, "R1 status after reset");
    rd_check('h08, 32'h0, "R1 raw irq after reset");
    rd_check('h00, 32'h0, "R1 enable after reset");
    check(irq == 1'b0, "R1 irq after reset", 64'(irq), 64'd0);
    check(fl_req_valid == 1'b0, "R1 valid after reset", 64'(fl_req_valid), 64'd0);

    // Read with back-pressure
    fl_req_ready = 1'b0;
    wr('h1C, 32'h0012_3457);
    push(3'd1, 22'h12_3450, 32'h0);
    wr('h14, 32'h1);
    rd_check('h18, 32'h01, "R2 pending after command write");
    check(fl_req_valid == 1'b1, "R2 valid after command write", 64'(fl_req_valid), 64'd1);
    tick();
    check(fl_req_valid == 1'b1, "R3 valid holds without ready", 64'(fl_req_valid), 64'd1);
    fl_req_ready = 1'b1;
    tick();
    rd_check('h18, 32'h02, "R3 accepted and not pending");
    fdone(1'b0, 128'h44444444_33333333_22222222_11111111);
    rd_check('h20, 32'h11111111, "R4 data word 0");
    rd_check('h24, 32'h22222222, "R4 data word 1");
    rd_check('h2C, 32'h44444444, "R4 data word 3");
    rd_check('h18, 32'h06, "R6 success posted");
    check(irq == 1'b0, "R12 irq masked off", 64'(irq), 64'd0);

    // R12 interrupt registers
    wr('h00, 32'h2);
    rd_check('h10, 32'h02, "R12 masked status");
    check(irq == 1'b1, "R12 irq with enable", 64'(irq), 64'd1);
    wr('h04, 32'h2);
    check(irq == 1'b0, "R12 irq after enable clear", 64'(irq), 64'd0);
    rd_check('h00, 32'h0, "R12 enable readback");
    wr('h08, 32'hE0);
    rd_check('h08, 32'h03, "R12 upper bits absent");
    wr('h08, 32'h10);
    rd_check('h08, 32'h13, "R12 software set");
    wr('h0C, 32'h1F);
    rd_check('h08, 32'h00, "R12 software clear");

    // Word write
    wr('h20, 32'hCAFE_F00D);
    wr('h1C, 32'h100);
    push(3'd2, 22'h100, 32'hCAFE_F00D);
    wr('h14, 32'h2);
    tick();
    wr('h20, 32'h1234_5678);
    fdone(1'b0, '0);
    rd_check('h18, 32'h06, "R6 word write success");

    // R7 finished while success uncleared, then deferred fail
    wr('h20, 32'h5555_AAAA);
    wr('h1C, 32'h104);
    push(3'd2, 22'h104, 32'h5555_AAAA);
    wr('h14, 32'h2);
    tick();
    fdone(1'b1, '0);
    rd_check('h18, 32'h16, "R7 finished flagged, result held");
    wr('h0C, 32'h1F);
    rd_check('h18, 32'h10, "R7 finished remains until post");
    tick();
    rd_check('h18, 32'h08, "R7 deferred fail posted");
    wr('h0C, 32'h1F);

    // R8 row-write pipeline
    fl_req_ready = 1'b0;
    wr('h20, 32'hA1);
    wr('h1C, 32'h200);
    push(3'd3, 22'h200, 32'hA1);
    wr('h14, 32'h3);
    fl_req_ready = 1'b1;
    tick();
    fl_req_ready = 1'b0;
    wr('h20, 32'hB2);
    wr('h1C, 32'h204);
    push(3'd3, 22'h204, 32'hB2);
    wr('h14, 32'h3);
    check(fl_req_valid == 1'b1, "R8 second row write offered", 64'(fl_req_valid), 64'd1);
    fl_req_ready = 1'b1;
    tick();
    wr('h20, 32'hC3);
    wr('h1C, 32'h300);
    push(3'd2, 22'h300, 32'hC3);
    wr('h14, 32'h2);
    check(fl_req_valid == 1'b0, "R8 word write waits behind rows", 64'(fl_req_valid), 64'd0);
    rd_check('h18, 32'h03, "R8 pending behind rows");
    fdone(1'b0, '0);
    rd_check('h18, 32'h07, "R8 accepted and success together");
    check(fl_req_valid == 1'b0, "R8 still waits with one row out", 64'(fl_req_valid), 64'd0);
    fdone(1'b0, '0);
    tick();
    fdone(1'b0, '0);
    wr('h0C, 32'h1F);
    tick();
    wr('h0C, 32'h1F);
    rd_check('h18, 32'h00, "R7 all results drained");

    // R9 overflow, R11 abort
    fl_req_ready = 1'b0;
    wr('h1C, 32'h400);
    wr('h14, 32'h4);
    rd_check('h18, 32'h01, "R2 page erase pending");
    wr('h14, 32'h2);
    rd_check('h08, 32'h10, "R9 overflow raised");
    wr('h14, 32'h12);
    check(fl_req_valid == 1'b0, "R11 abort drops request", 64'(fl_req_valid), 64'd0);
    rd_check('h18, 32'h00, "R11 pending cleared by abort");
    rd_check('h08, 32'h10, "R11 abort code field ignored");
    fl_req_ready = 1'b1;
    repeat (3) tick();
    check(fl_req_valid == 1'b0, "R11 nothing issued after abort", 64'(fl_req_valid), 64'd0);
    wr('h0C, 32'h1F);

    // R10 reject
    wr('h14, 32'h5);
    rd_check('h08, 32'h08, "R10 unused code rejected");
    check(fl_req_valid == 1'b0, "R10 no request for unused code", 64'(fl_req_valid), 64'd0);
    arb_locked = 1'b1;
    rd_check('h18, 32'h20, "R10 lock shown in status");
    wr('h14, 32'h1);
    check(fl_req_valid == 1'b0, "R10 no request while locked", 64'(fl_req_valid), 64'd0);
    rd_check('h18, 32'h20, "R10 locked command not pending");
    arb_locked = 1'b0;
    wr('h0C, 32'h1F);
    wr('h14, 32'h0);
    rd_check('h08, 32'h00, "R10 code zero has no effect");

    // R5 mass erase scope bit
    wr('h1C, 32'h0020_0010);
    push(3'd7, 22'h20_0010, 32'h0);
    wr('h14, 32'h7);
    tick();
    fdone(1'b0, '0);
    wr('h0C, 32'h1F);
    wr('h1C, 32'h20);
    push(3'd7, 22'h00_0020, 32'h0);
    wr('h14, 32'h7);
    tick();
    fdone(1'b0, '0);
    wr('h0C, 32'h1F);

    repeat (5) tick();
    check(exp_q.size() == 0, "R2 every command issued", 64'(exp_q.size()), 64'd0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule